// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 14-bit virtual address into a physical address by walking a two-level page table kept in memory. The virtual page number is cut in two. Its upper half picks an entry in a directory that sits at a root frame. That entry names the frame of a sub-table, and the lower half of the page number picks a leaf entry inside that sub-table. The leaf entry supplies the physical frame. The 64-byte page offset passes through unchanged. Each level costs one memory read. A directory entry that is not valid ends the walk after the first read, so sub-tables that are empty need not exist in memory at all.

Requests come in and results go out over valid/ready channels. A request moves on a clock edge where `req_valid` and `req_ready` are both high. A result stays on the outputs, unchanged, until the edge where `rsp_ready` is high. Memory is reached through a request channel that the walker holds until the memory accepts it, and through a one-cycle response strobe that may come back any number of cycles later. `root_frame` is a plain control input, and the walker samples it when it accepts a request.

Top module: `walk_top`

## Requirements
- R1: The first read of a walk goes to byte address root_frame*64 + vaddr[13:10]*4, using the root frame that was sampled when the request was accepted.
- R2: After a valid directory entry, the second read goes to byte address F*64 + vaddr[9:6]*4, where F is the frame held in that directory entry.
- R3: In a 32-bit entry, bit 31 is the valid flag and bits 7:0 hold the frame number. Bits 30:8 have no effect.
- R4: When the directory entry is not valid, the result has rsp_fault=1 and rsp_fault_leaf=0, and the walk makes exactly one memory read.
- R5: When the leaf entry is not valid, the result has rsp_fault=1, rsp_fault_leaf=1 and rsp_paddr=0, and the walk makes exactly two memory reads.
- R6: When both entries are valid, the result has rsp_fault=0 and rsp_paddr = {leaf frame, vaddr[5:0]}, and the walk makes exactly two reads.
- R7: req_ready is high only when the walker is idle. It goes low on the cycle after a request is accepted.
- R8: Once mem_req_valid is high, it stays high and mem_req_addr stays unchanged until a cycle in which mem_req_ready is high.
- R9: rsp_valid and the result fields stay high and unchanged until rsp_ready is high. On the next cycle the walker is idle again.
- R10: After reset, req_ready=1, mem_req_valid=0 and rsp_valid=0.
- R11: Changes to root_frame after a request has been accepted do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| root_frame | input | 8 | Frame number of the directory |
| req_valid | input | 1 | Translation request is valid |
| req_ready | output | 1 | Walker is idle and can take a request |
| req_vaddr | input | 14 | Virtual address to translate |
| rsp_valid | output | 1 | Result is valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 14 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | The walk found an entry that is not valid |
| rsp_fault_leaf | output | 1 | The fault came from the leaf level |
| mem_req_valid | output | 1 | Memory read request is valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 14 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | One-cycle strobe that carries the read data |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The assertions assume that memory returns exactly one response strobe for each accepted read, and only while the walker is waiting for that read. They also assume that the consumer never sees a result before the walker raises rsp_valid. The bench memory model keeps to these rules: it raises mem_req_ready only while a read is pending, and it answers each read once, after a latency that varies. Stalls on the request channel and on the result channel change from walk to walk, so the bench exercises back-pressure on both channels without ever breaking the handshake rules.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/walk_index.sv
// Forms the byte address of one table entry: base frame * page size + index * entry size.
module walk_index #(
  parameter int FRAME_W   = 8,
  parameter int IDX_W     = 4,
  parameter int OFF_W     = 6,
  parameter int ENT_SHIFT = 2
) (
  input  logic [FRAME_W-1:0]       base_frame,
  input  logic [IDX_W-1:0]         idx,
  output logic [FRAME_W+OFF_W-1:0] addr
);
  localparam int PA_W = FRAME_W + OFF_W;

  always_comb begin
    addr = (PA_W'(base_frame) << OFF_W) + (PA_W'(idx) << ENT_SHIFT);
  end
endmodule

// File: rtl/walk_entry.sv
// Splits a table entry into its valid flag (top bit) and its frame number (low bits).
module walk_entry #(
  parameter int ENT_W   = 32,
  parameter int FRAME_W = 8
) (
  input  logic [ENT_W-1:0]   data,
  output logic               vld,
  output logic [FRAME_W-1:0] frame
);
  always_comb begin
    vld   = data[ENT_W-1];
    frame = data[FRAME_W-1:0];
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int DIR_W   = 4,
  parameter int TBL_W   = 4,
  parameter int OFF_W   = 6,
  parameter int FRAME_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FRAME_W-1:0]         root_frame,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_vaddr,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
  output logic                       rsp_fault,
  output logic                       rsp_fault_leaf,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  input  logic                       mem_rsp_valid,
  input  logic                       ent_vld,
  input  logic [FRAME_W-1:0]         ent_frame,
  output logic                       sel_leaf,
  output logic [FRAME_W-1:0]         root_q,
  output logic [FRAME_W-1:0]         sub_q,
  output logic [DIR_W-1:0]           dir_idx,
  output logic [TBL_W-1:0]           tbl_idx
);
  localparam int VA_W = DIR_W + TBL_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;

  walk_state_t       state;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   pa_q;
  logic              fault_q;
  logic              leaf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      sub_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      leaf_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          root_q <= root_frame;
          state  <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (ent_vld) begin
            sub_q <= ent_frame;
            state <= ST_LEAF_REQ;
          end else begin
            fault_q <= 1'b1;
            leaf_q  <= 1'b0;
            pa_q    <= '0;
            state   <= ST_DONE;
          end
        end
        ST_LEAF_REQ: if (mem_req_ready) state <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: if (mem_rsp_valid) begin
          leaf_q <= !ent_vld;
          fault_q <= !ent_vld;
          pa_q   <= ent_vld ? {ent_frame, va_q[OFF_W-1:0]} : '0;
          state  <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready      = (state == ST_IDLE);
    mem_req_valid  = (state == ST_DIR_REQ) || (state == ST_LEAF_REQ);
    sel_leaf       = (state == ST_LEAF_REQ);
    rsp_valid      = (state == ST_DONE);
    rsp_paddr      = pa_q;
    rsp_fault      = fault_q;
    rsp_fault_leaf = leaf_q;
    dir_idx        = va_q[VA_W-1 -: DIR_W];
    tbl_idx        = va_q[OFF_W +: TBL_W];
  end

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_req_valid));

  assert_dir_fault_one_read_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIR_WAIT && mem_rsp_valid && !ent_vld) |=>
      (rsp_valid && rsp_fault && !rsp_fault_leaf));

  assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_leaf)));

  assert_idle_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> req_ready);
endmodule

// File: rtl/walk_top.sv
module walk_top #(
  parameter int DIR_W   = 4,
  parameter int TBL_W   = 4,
  parameter int OFF_W   = 6,
  parameter int FRAME_W = 8,
  parameter int ENT_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [FRAME_W-1:0]           root_frame,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_vaddr,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [FRAME_W+OFF_W-1:0]     rsp_paddr,
  output logic                         rsp_fault,
  output logic                         rsp_fault_leaf,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [FRAME_W+OFF_W-1:0]     mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [ENT_W-1:0]             mem_rsp_data
);
  localparam int PA_W      = FRAME_W + OFF_W;
  localparam int ENT_SHIFT = $clog2(ENT_W / 8);

  logic               ent_vld;
  logic [FRAME_W-1:0] ent_frame;
  logic               sel_leaf;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] sub_q;
  logic [DIR_W-1:0]   dir_idx;
  logic [TBL_W-1:0]   tbl_idx;
  logic [PA_W-1:0]    dir_addr;
  logic [PA_W-1:0]    leaf_addr;

  walk_entry #(.ENT_W(ENT_W), .FRAME_W(FRAME_W)) u_entry (
    .data(mem_rsp_data), .vld(ent_vld), .frame(ent_frame)
  );

  walk_index #(.FRAME_W(FRAME_W), .IDX_W(DIR_W), .OFF_W(OFF_W), .ENT_SHIFT(ENT_SHIFT)) u_dir_idx (
    .base_frame(root_q), .idx(dir_idx), .addr(dir_addr)
  );

  walk_index #(.FRAME_W(FRAME_W), .IDX_W(TBL_W), .OFF_W(OFF_W), .ENT_SHIFT(ENT_SHIFT)) u_leaf_idx (
    .base_frame(sub_q), .idx(tbl_idx), .addr(leaf_addr)
  );

  walk_ctrl #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst(rst), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_leaf(rsp_fault_leaf),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .ent_vld(ent_vld), .ent_frame(ent_frame),
    .sel_leaf(sel_leaf), .root_q(root_q), .sub_q(sub_q),
    .dir_idx(dir_idx), .tbl_idx(tbl_idx)
  );

  always_comb begin
    mem_req_addr = sel_leaf ? leaf_addr : dir_addr;
  end

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_no_read_while_done_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);
endmodule

// File: tb/walk_top_test.sv
`timescale 1ns/1ps
module walk_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  root_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [13:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_leaf;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [13:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  int hs_cnt = 0;
  logic [7:0]  cur_root = '0;
  logic [13:0] cur_va = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  walk_top uut (
    .clk(clk), .rst(rst), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_leaf(rsp_fault_leaf),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Directory i valid unless (i+root)%5==3, pointing at frame 16+i.
  function automatic bit dir_ok(input int r, input int i);
    return ((i + r) % 5) != 3;
  endfunction
  // Leaf (i,j) valid unless (3i+j)%7==0; frame computed arithmetically.
  function automatic bit leaf_ok(input int i, input int j);
    return ((i * 3 + j) % 7) != 0;
  endfunction
  function automatic int leaf_frame(input int i, input int j);
    return ((i * 16 + j) * 5 + 1) % 256;
  endfunction

  // Memory contents; bits 30:8 carry junk the walker must ignore (R3).
  function automatic logic [31:0] mem_word(input logic [13:0] a);
    int f = a[13:6];
    int x = a[5:2];
    logic [31:0] w = {1'b0, 23'h2AAAAA, 8'h00};
    if (f == 2 || f == 3) begin
      w[31]  = dir_ok(f, x);
      w[7:0] = 8'(16 + x);
    end else if (f >= 16 && f < 32) begin
      w[31]  = leaf_ok(f - 16, x);
      w[7:0] = 8'(leaf_frame(f - 16, x));
    end
    return w;
  endfunction

  // Memory responder: variable stall before accept, variable latency after.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst && mem_req_valid) begin
        logic [13:0] a;
        logic [13:0] exp_a;
        int stall = hs_cnt % 3;
        int lat = (hs_cnt * 7) % 4;
        repeat (stall) @(negedge clk);
        a = mem_req_addr;
        if (nreads == 0) begin
          exp_a = 14'(int'(cur_root) * 64 + int'(cur_va[13:10]) * 4);
          check(a == exp_a, "R1 dir address", a, exp_a);
        end else begin
          exp_a = 14'((16 + int'(cur_va[13:10])) * 64 + int'(cur_va[9:6]) * 4);
          check(a == exp_a, "R2 leaf address", a, exp_a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        nreads++;
        hs_cnt++;
        repeat (lat) @(negedge clk);
        mem_rsp_data  = mem_word(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic walk(input logic [7:0] r, input logic [13:0] va, input int hold);
    int d = va[13:10];
    int t = va[9:6];
    bit dv, lv;
    logic [13:0] snap;
    logic [13:0] exp_pa;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nreads = 0;
    cur_root = r;
    cur_va = va;
    root_frame = r;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    root_frame = ~r; // R11: must not affect this walk
    check(!req_ready, "R7 busy after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    snap = rsp_paddr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == snap, "R9 result held", rsp_paddr, snap);
    end
    dv = dir_ok(r, d);
    lv = leaf_ok(d, t);
    if (!dv) begin
      check(rsp_fault && !rsp_fault_leaf, "R4 dir fault flags", {rsp_fault, rsp_fault_leaf}, 2);
      check(nreads == 1, "R4 one read", nreads, 1);
    end else if (!lv) begin
      check(rsp_fault && rsp_fault_leaf, "R5 leaf fault flags", {rsp_fault, rsp_fault_leaf}, 3);
      check(rsp_paddr == 0, "R5 zero address", rsp_paddr, 0);
      check(nreads == 2, "R5 two reads", nreads, 2);
    end else begin
      exp_pa = {8'(leaf_frame(d, t)), va[5:0]};
      check(!rsp_fault, "R6 no fault", rsp_fault, 0);
      check(rsp_paddr == exp_pa, "R6 R3 R11 physical address", rsp_paddr, exp_pa);
      check(nreads == 2, "R6 two reads", nreads, 2);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R9 idle after take", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    check(mem_req_valid == 1'b0, "R10 mem_req_valid", mem_req_valid, 0);
    check(rsp_valid == 1'b0, "R10 rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    for (int r = 2; r <= 3; r++) begin
      for (int v = 0; v < 256; v++) begin
        walk(8'(r), {8'(v), 6'((v * 13 + r) % 64)}, (v + r) % 3);
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule